// File: doc/BRIEF.md
# Serial Terminal Register and Interrupt Interface

This block is a byte-wide bus-slave register interface for a serial terminal. On the host side it takes single accesses in the Wishbone classic style over a 4-bit address. On the line side it feeds an external shift-register transmitter with a byte stream and takes bytes from an external deserializer. The bit-level serial framing, the baud generation and the line handling are not part of it.

The block holds a small first-in first-out buffer in each direction. It keeps four sticky status flags. Each flag is set when its condition goes from low to high, and each stays set until software acknowledges it. The transmit flags are acknowledged as a pair and the receive flags as a pair. One level interrupt output is raised when an enabled flag rises.

Both byte streams use valid/ready. On the transmit stream, `tx_valid_o` is high while the transmit buffer holds a byte. `tx_data_o` is the oldest byte and stays stable until `tx_ready_i` is seen high at a clock edge. On the receive stream, `rx_ready_o` drops while the receive buffer is full. A byte offered with `rx_valid_i` is taken only at an edge where both signals are high. The source must hold the byte until then.

Top module: `sterm_regif`

## Requirements
- R1: Address 4'b0100 reads the status byte and so does address 4'b0110. The status byte holds bit7 = receive buffer full, bit5 = receive not empty, bit3 = transmit shifter empty, bit1 = transmit buffer empty and bit0 = transmit buffer full. Bits 6, 4 and 2 always read 0.
- R2: After reset the status byte is 8'h0A, the enable byte (address 4'b0101) is 8'h00 and `irq_o` is low.
- R3: A write to 4'b0101 stores only data bits 5 and 1. All other bits read back as 0.
- R4: Every access is acknowledged by a one-cycle `wb_ack_o` pulse in the clock after `wb_cyc_i` and `wb_stb_i` are both high. Read data is valid with that acknowledge.
- R5: A write to 4'b0110 with data bit1 set clears the transmit-empty and shifter-empty flags. Data bit5 set clears the receive-not-empty and receive-full flags. A pair whose bit is 0 is unchanged.
- R6: The flags on bits 1, 3, 5 and 7 are sticky. Each is set one clock after its condition rises, and a set takes priority over a clear in the same cycle. The transmit-full flag on bit 0 follows the buffer level directly.
- R7: `irq_o` rises together with the transmit-empty or receive-not-empty flag when that flag rises while its enable bit (1 or 5) is set. It stays high until that flag is cleared or its enable is dropped. Enabling a flag that is already set does not raise it.
- R8: A write to 4'b0111 appends a byte to the 4-entry transmit buffer. The bytes leave on the transmit stream in write order, and each is removed on a valid-and-ready edge.
- R9: A write to 4'b0111 while the transmit buffer is full replaces the newest buffered byte and does not change the level.
- R10: A read of 4'b0111 returns and removes the oldest byte of the 4-entry receive buffer. On an empty buffer the read removes nothing.
- R11: `rx_ready_o` is low exactly while the receive buffer holds 4 bytes. A byte offered while it is low is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wb_cyc_i | input | 1 | Bus cycle |
| wb_stb_i | input | 1 | Bus strobe |
| wb_we_i | input | 1 | Write enable |
| wb_adr_i | input | 4 | Register address |
| wb_dat_i | input | 8 | Write data |
| wb_dat_o | output | 8 | Read data |
| wb_ack_o | output | 1 | Access acknowledge |
| irq_o | output | 1 | Level interrupt |
| tx_valid_o | output | 1 | Transmit byte available |
| tx_ready_i | input | 1 | Transmitter takes the byte |
| tx_data_o | output | 8 | Oldest transmit byte |
| tx_idle_i | input | 1 | Transmit shift register idle |
| rx_valid_i | input | 1 | Received byte offered |
| rx_ready_o | output | 1 | Receive buffer has room |
| rx_data_i | input | 8 | Received byte |

## Verification
The bench writes a fifth byte into a stalled, full transmit buffer and checks the order that drains. A design that refused the byte, or that overwrote the oldest byte instead of the newest, sends the wrong fourth byte. It offers a byte to a full receive buffer and reads an empty one, then pushes one more byte. A design that accepts under back-pressure, or that pops when empty, returns a stale or out-of-order byte. It clears each flag pair separately and checks that the other pair survives. It re-enables an interrupt whose flag is already set. A design that drives the interrupt from the flag level instead of its rising edge asserts `irq_o` there.

// File: rtl/sterm_pkg.sv
package sterm_pkg;
  localparam int BYTE_W = 8;
  localparam int REG_AW = 4;

  localparam logic [REG_AW-1:0] ADR_STAT = 4'b0100;
  localparam logic [REG_AW-1:0] ADR_IEN  = 4'b0101;
  localparam logic [REG_AW-1:0] ADR_IACK = 4'b0110;
  localparam logic [REG_AW-1:0] ADR_DATA = 4'b0111;

  // status byte bit positions (software decodes these)
  localparam int B_RXFULL = 7;
  localparam int B_RXNE   = 5;
  localparam int B_TXSHE  = 3;
  localparam int B_TXE    = 1;
  localparam int B_TXFULL = 0;

  localparam logic [BYTE_W-1:0] IEN_MASK = 8'h22;

  // sticky flag slots inside the flag bank
  typedef enum logic [1:0] {
    FL_TXE   = 2'd0,
    FL_TXSHE = 2'd1,
    FL_RXNE  = 2'd2,
    FL_RXF   = 2'd3
  } flag_idx_e;
  localparam int NUM_FLAGS = 4;
  localparam logic [NUM_FLAGS-1:0] FLAG_RST = 4'b0011;

  typedef struct packed {
    logic rd_data;
    logic wr_data;
    logic wr_ien;
    logic wr_iack;
  } acc_t;
endpackage

// File: rtl/sterm_fifo.sv
module sterm_fifo #(
  parameter int W         = 8,
  parameter int DEPTH     = 4,
  parameter bit OVERWRITE = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr, newest;
  logic [CW-1:0] cnt;
  logic          do_pop, do_push, do_ovw;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [AW-1:0] ptr_dec(input logic [AW-1:0] p);
    return (p == '0) ? LAST : p - 1'b1;
  endfunction

  assign full   = (cnt == FULL_CNT);
  assign empty  = (cnt == '0);
  assign rdata  = mem[rd_ptr];
  assign newest = ptr_dec(wr_ptr);
  assign do_pop = pop & ~empty;

  generate
    if (OVERWRITE) begin : g_ovw
      assign do_push = push & (~full | do_pop);
      assign do_ovw  = push & full & ~do_pop;
    end else begin : g_drop
      assign do_push = push & ~full;
      assign do_ovw  = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (do_push)
      mem[wr_ptr] <= wdata;
    else if (do_ovw)
      mem[newest] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_inc(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_inc(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/sterm_stick_flag.sv
module sterm_stick_flag #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cond,
  input  logic clr,
  output logic flag,
  output logic set_p,
  output logic flag_n
);
  logic cond_q;

  assign set_p  = cond & ~cond_q;
  assign flag_n = set_p | (flag & ~clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond_q <= RST_VAL;
      flag   <= RST_VAL;
    end else begin
      cond_q <= cond;
      flag   <= flag_n;
    end
  end
endmodule

// File: rtl/sterm_flags.sv
module sterm_flags
  import sterm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_empty_c,
  input  logic              tx_idle_c,
  input  logic              rx_nempty_c,
  input  logic              rx_full_c,
  input  logic              tx_full_c,
  input  logic              clr_tx,
  input  logic              clr_rx,
  input  logic              en_tx,
  input  logic              en_rx,
  output logic [BYTE_W-1:0] status,
  output logic              irq
);
  logic [NUM_FLAGS-1:0] cond, clr, flag, set_p, flag_n;
  logic pend_tx, pend_rx;

  assign cond[FL_TXE]   = tx_empty_c;
  assign cond[FL_TXSHE] = tx_idle_c;
  assign cond[FL_RXNE]  = rx_nempty_c;
  assign cond[FL_RXF]   = rx_full_c;
  assign clr[FL_TXE]    = clr_tx;
  assign clr[FL_TXSHE]  = clr_tx;
  assign clr[FL_RXNE]   = clr_rx;
  assign clr[FL_RXF]    = clr_rx;

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    sterm_stick_flag #(.RST_VAL(FLAG_RST[g])) u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .cond   (cond[g]),
      .clr    (clr[g]),
      .flag   (flag[g]),
      .set_p  (set_p[g]),
      .flag_n (flag_n[g])
    );
  end

  always_comb begin
    status           = '0;
    status[B_RXFULL] = flag[FL_RXF];
    status[B_RXNE]   = flag[FL_RXNE];
    status[B_TXSHE]  = flag[FL_TXSHE];
    status[B_TXE]    = flag[FL_TXE];
    status[B_TXFULL] = tx_full_c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_tx <= 1'b0;
      pend_rx <= 1'b0;
    end else begin
      pend_tx <= en_tx & (pend_tx | set_p[FL_TXE])  & flag_n[FL_TXE];
      pend_rx <= en_rx & (pend_rx | set_p[FL_RXNE]) & flag_n[FL_RXNE];
    end
  end

  assign irq = pend_tx | pend_rx;
endmodule

// File: rtl/sterm_regif.sv
module sterm_regif
  import sterm_pkg::*;
#(
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wb_cyc_i,
  input  logic              wb_stb_i,
  input  logic              wb_we_i,
  input  logic [REG_AW-1:0] wb_adr_i,
  input  logic [BYTE_W-1:0] wb_dat_i,
  output logic [BYTE_W-1:0] wb_dat_o,
  output logic              wb_ack_o,
  output logic              irq_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  output logic [BYTE_W-1:0] tx_data_o,
  input  logic              tx_idle_i,
  input  logic              rx_valid_i,
  output logic              rx_ready_o,
  input  logic [BYTE_W-1:0] rx_data_i
);
  logic              req;
  acc_t              acc;
  logic [BYTE_W-1:0] ien_q, status_q, rd_mux, rx_head;
  logic              tx_full, tx_empty, rx_full, rx_empty;

  // a new access starts when the bus asks and no acknowledge is pending
  assign req = wb_cyc_i & wb_stb_i & ~wb_ack_o;

  always_comb begin
    acc         = '0;
    acc.rd_data = req & ~wb_we_i & (wb_adr_i == ADR_DATA);
    acc.wr_data = req &  wb_we_i & (wb_adr_i == ADR_DATA);
    acc.wr_ien  = req &  wb_we_i & (wb_adr_i == ADR_IEN);
    acc.wr_iack = req &  wb_we_i & (wb_adr_i == ADR_IACK);
  end

  always_comb begin
    unique case (wb_adr_i)
      ADR_STAT, ADR_IACK: rd_mux = status_q;
      ADR_IEN:            rd_mux = ien_q;
      ADR_DATA:           rd_mux = rx_empty ? '0 : rx_head;
      default:            rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_ack_o <= 1'b0;
      wb_dat_o <= '0;
      ien_q    <= '0;
    end else begin
      wb_ack_o <= req;
      if (req && !wb_we_i) wb_dat_o <= rd_mux;
      if (acc.wr_ien) ien_q <= wb_dat_i & IEN_MASK;
    end
  end

  sterm_fifo #(.W(BYTE_W), .DEPTH(TX_DEPTH), .OVERWRITE(1'b1)) u_txbuf (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (acc.wr_data),
    .wdata (wb_dat_i),
    .pop   (tx_ready_i),
    .rdata (tx_data_o),
    .full  (tx_full),
    .empty (tx_empty)
  );

  sterm_fifo #(.W(BYTE_W), .DEPTH(RX_DEPTH), .OVERWRITE(1'b0)) u_rxbuf (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (rx_valid_i),
    .wdata (rx_data_i),
    .pop   (acc.rd_data),
    .rdata (rx_head),
    .full  (rx_full),
    .empty (rx_empty)
  );

  assign tx_valid_o = ~tx_empty;
  assign rx_ready_o = ~rx_full;

  sterm_flags u_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_empty_c  (tx_empty),
    .tx_idle_c   (tx_idle_i),
    .rx_nempty_c (~rx_empty),
    .rx_full_c   (rx_full),
    .tx_full_c   (tx_full),
    .clr_tx      (acc.wr_iack & wb_dat_i[B_TXE]),
    .clr_rx      (acc.wr_iack & wb_dat_i[B_RXNE]),
    .en_tx       (ien_q[B_TXE]),
    .en_rx       (ien_q[B_RXNE]),
    .status      (status_q),
    .irq         (irq_o)
  );
endmodule

// File: rtl/sterm_regif_chk.sv
module sterm_regif_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cyc,
  input logic       stb,
  input logic       ack,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] tx_data,
  input logic       rx_ready,
  input logic       irq,
  input logic [7:0] status_q
);
  // R4
  ack_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc && stb && !ack) |=> ack);

  // R4
  ack_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  // R8
  tx_hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  // R11
  rx_full_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_ready) |=> status_q[7]);

  // R7
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status_q[1] || status_q[5]));

  // R1
  unused_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[6] == 1'b0) && (status_q[4] == 1'b0) && (status_q[2] == 1'b0));
endmodule

bind sterm_regif sterm_regif_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .cyc      (wb_cyc_i),
  .stb      (wb_stb_i),
  .ack      (wb_ack_o),
  .tx_valid (tx_valid_o),
  .tx_ready (tx_ready_i),
  .tx_data  (tx_data_o),
  .rx_ready (rx_ready_o),
  .irq      (irq_o),
  .status_q (status_q)
);

// File: tb/sterm_regif_tb_top.sv
`timescale 1ns/1ps
module sterm_regif_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc = 0, stb = 0, we = 0;
  logic [3:0] adr = '0;
  logic [7:0] wdat = '0;
  logic [7:0] rdat;
  logic       ack, irq, tx_valid, rx_ready;
  logic       tx_ready = 0, tx_idle = 1, rx_valid = 0;
  logic [7:0] tx_data, rx_data = '0;
  int         n_chk = 0, n_fail = 0;
  logic [7:0] got;

  always #2 clk = ~clk;

  sterm_regif dut_i (
    .clk(clk), .rst_n(rst_n),
    .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we), .wb_adr_i(adr),
    .wb_dat_i(wdat), .wb_dat_o(rdat), .wb_ack_o(ack), .irq_o(irq),
    .tx_valid_o(tx_valid), .tx_ready_i(tx_ready), .tx_data_o(tx_data),
    .tx_idle_i(tx_idle), .rx_valid_i(rx_valid), .rx_ready_o(rx_ready),
    .rx_data_i(rx_data)
  );

  typedef struct packed {
    logic       wr;
    logic [3:0] a;
    logic [7:0] d;
    logic       chk;
    logic [7:0] exp;
  } vec_t;

  // register-level walk right after reset (tx_idle held high)
  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 4'h4, 8'h00, 1'b1, 8'h0A},   // R2 R1 status
    '{1'b0, 4'h6, 8'h00, 1'b1, 8'h0A},   // R1 alias
    '{1'b0, 4'h5, 8'h00, 1'b1, 8'h00},   // R2 enables
    '{1'b1, 4'h5, 8'hFF, 1'b0, 8'h00},
    '{1'b0, 4'h5, 8'h00, 1'b1, 8'h22},   // R3 mask
    '{1'b1, 4'h5, 8'h00, 1'b0, 8'h00},
    '{1'b0, 4'h5, 8'h00, 1'b1, 8'h00},   // R3
    '{1'b1, 4'h6, 8'h20, 1'b0, 8'h00},   // R5 rx pair only
    '{1'b0, 4'h4, 8'h00, 1'b1, 8'h0A},   // R5 tx pair kept
    '{1'b1, 4'h6, 8'h02, 1'b0, 8'h00},   // R5 tx pair
    '{1'b0, 4'h4, 8'h00, 1'b1, 8'h00},   // R5
    '{1'b0, 4'h6, 8'h00, 1'b1, 8'h00}    // R1 alias
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at a falling edge
  task automatic bus(input logic w, input logic [3:0] a, input logic [7:0] d,
                     output logic [7:0] r);
    cyc = 1; stb = 1; we = w; adr = a; wdat = d;
    @(negedge clk);
    check("R4 ack", {7'b0, ack}, 8'h01);
    r = rdat;
    cyc = 0; stb = 0; we = 0;
    @(negedge clk);
    check("R4 ack drop", {7'b0, ack}, 8'h00);
  endtask

  task automatic rx_push(input logic [7:0] b);
    rx_valid = 1; rx_data = b;
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [7:0] exp_tx [4];
    exp_tx = '{8'hA1, 8'hA2, 8'hA3, 8'hA5};
    idle(3);
    rst_n = 1'b1;
    idle(1);
    check("R2 irq", {7'b0, irq}, 8'h00);
    check("R11 rx_ready", {7'b0, rx_ready}, 8'h01);

    for (int i = 0; i < NV; i++) begin
      bus(VECS[i].wr, VECS[i].a, VECS[i].d, got);
      if (VECS[i].chk) check("R1/R2/R3/R5 vector", got, VECS[i].exp);
      check("R7 no irq while disabled", {7'b0, irq}, 8'h00);
    end

    // transmit path: stall, fill, overwrite, drain
    bus(1, 4'h5, 8'h22, got);
    bus(1, 4'h7, 8'hA1, got);
    bus(1, 4'h7, 8'hA2, got);
    bus(1, 4'h7, 8'hA3, got);
    bus(1, 4'h7, 8'hA4, got);
    bus(0, 4'h4, 8'h00, got);
    check("R6 txfull live", got, 8'h01);
    check("R8 head", tx_data, 8'hA1);
    bus(1, 4'h7, 8'hA5, got);                // R9 overwrite newest
    bus(0, 4'h4, 8'h00, got);
    check("R9 level unchanged", got, 8'h01);
    tx_idle = 0;
    tx_ready = 1;
    for (int i = 0; i < 4; i++) begin
      check("R8 R9 drain order", tx_data, exp_tx[i]);
      @(negedge clk);
    end
    tx_ready = 0;
    check("R8 drained", {7'b0, tx_valid}, 8'h00);
    idle(2);
    check("R7 tx irq", {7'b0, irq}, 8'h01);
    bus(0, 4'h4, 8'h00, got);
    check("R6 txempty set", got, 8'h02);
    tx_idle = 1;
    idle(2);
    bus(0, 4'h4, 8'h00, got);
    check("R6 txshempty set", got, 8'h0A);
    bus(1, 4'h6, 8'h02, got);
    check("R7 irq cleared", {7'b0, irq}, 8'h00);
    bus(0, 4'h4, 8'h00, got);
    check("R5 tx cleared", got, 8'h00);

    // receive path
    rx_push(8'hB1);
    rx_push(8'hB2);
    rx_push(8'hB3);
    rx_push(8'hB4);
    idle(2);
    check("R11 full", {7'b0, rx_ready}, 8'h00);
    check("R7 rx irq", {7'b0, irq}, 8'h01);
    bus(0, 4'h4, 8'h00, got);
    check("R6 rx flags", got, 8'hA0);
    rx_valid = 1; rx_data = 8'hEE;          // R11 offered while full
    idle(3);
    rx_valid = 0;
    for (int i = 0; i < 4; i++) begin
      bus(0, 4'h7, 8'h00, got);
      check("R10 R11 read order", got, 8'hB1 + 8'(i));
    end
    bus(0, 4'h7, 8'h00, got);                // empty read, no pop
    rx_push(8'hC1);
    idle(1);
    bus(0, 4'h7, 8'h00, got);
    check("R10 after empty read", got, 8'hC1);
    bus(0, 4'h4, 8'h00, got);
    check("R6 sticky", got, 8'hA0);
    bus(1, 4'h6, 8'h20, got);
    check("R7 rx irq cleared", {7'b0, irq}, 8'h00);
    bus(0, 4'h6, 8'h00, got);
    check("R5 rx cleared", got, 8'h00);
    rx_push(8'hD1);
    idle(2);
    check("R7 rx irq again", {7'b0, irq}, 8'h01);
    bus(1, 4'h5, 8'h02, got);
    check("R7 enable dropped", {7'b0, irq}, 8'h00);
    bus(1, 4'h5, 8'h22, got);
    idle(1);
    check("R7 no irq on late enable", {7'b0, irq}, 8'h00);
    bus(0, 4'h4, 8'h00, got);
    check("R6 flag kept", got, 8'h20);
    bus(0, 4'h7, 8'h00, got);
    check("R10 last byte", got, 8'hD1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #400000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule